// File: doc/BRIEF.md
# Programmable interval timer

This block is a down-counter that advances on a one-microsecond tick enable and signals expiry with a level-high interrupt. It has one configuration word. Its top bit turns the timer on and the next bit selects auto-reload. The low 29 bits give the count. A loaded count of N expires on the N+1-th tick, so software programs the wanted interval minus one.

In one-shot mode the timer turns itself off at expiry and holds a count of zero. In periodic mode it reloads the programmed count and keeps running. A second register reports the pending flag and the remaining count. Writing a one into bit 30 of that register drops the interrupt. Any write to the configuration word restarts the countdown at once. Writing zero to it stops the timer.

Top module: `interval_timer`

## Requirements
- R1: After reset, irq is 0 and both registers read as zero.
- R2: A write to the configuration word (wr_addr 0) stores enable from bit 31, periodic from bit 30 and the count from bits 28:0. Reading address 0 returns them in the same positions.
- R3: With a loaded count N and the timer enabled, the N+1-th tick expires the timer. irq is high from the clock edge that samples that tick.
- R4: While the timer is disabled, ticks have no effect on the remaining count.
- R5: In one-shot mode (bit 30 clear), expiry clears the enable bit, leaves the count at zero and produces no further expiries.
- R6: In periodic mode, expiry reloads the programmed count, so the timer expires once every N+1 ticks.
- R7: Writing zero to the configuration word stops the timer, sets the count to zero and produces no interrupt.
- R8: A write to the status register (wr_addr 1) with bit 30 set clears the pending interrupt. With bit 30 clear, the write has no effect.
- R9: The interrupt is level-high and stays asserted through further ticks until it is cleared.
- R10: A write to the configuration word while the timer runs restarts the countdown from the new value.
- R11: Reading the status register (rd_addr 1) returns the remaining count in bits 28:0 and the pending flag in bit 30. All other bits read as zero.
- R12: When an expiry and a clear fall in the same cycle, the interrupt stays pending.
- R13: Bit 29 of a configuration write is ignored and reads back as zero, and the full 29-bit count 0x1FFFFFFF is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle microsecond tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 configuration, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 configuration, 1 status |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
Register writes, ticks and clears are sampled at a rising edge. Their effect shows on rd_data and irq in the same cycle as that edge, because the read path is combinational. The bench drives every stimulus on a falling edge, releases it on the next falling edge, and reads the results right after that second falling edge. This means each check looks exactly one register stage after its stimulus. Expected counts and interrupt states come from closed-form functions of the loaded value, the mode and the number of ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int CLR_BIT = 30;

  typedef enum logic {
    SEL_CFG  = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] pack_cfg(logic en, logic per,
                                                 logic [PER_BIT-2:0] cnt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = en;
    w[PER_BIT] = per;
    w[PER_BIT-2:0] = cnt;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(logic pend,
                                                  logic [PER_BIT-2:0] cnt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CLR_BIT] = pend;
    w[PER_BIT-2:0] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en_in,
  input  logic             per_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             expire,
  output logic             en_q,
  output logic             per_q,
  output logic [CNT_W-1:0] reload_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      reload_q <= '0;
    end else if (load) begin
      en_q     <= en_in;
      per_q    <= per_in;
      reload_q <= cnt_in;
    end else if (expire && !per_q) begin
      en_q <= 1'b0;
    end
  end

  assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q && !load) |=> !en_q);
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q && !load) |=> en_q);
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  input  logic             per,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
                                                  logic p,
                                                  logic [CNT_W-1:0] rl);
    if (cur == '0) return p ? rl : '0;
    return cur - 1'b1;
  endfunction

  logic step;
  assign step   = run && tick && !load;
  assign expire = step && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_count(count, per, reload_val);
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run && tick)) |=> $stable(count));
  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count != '0) |=> (count == $past(count) - 1'b1));
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per) |=> (count == $past(reload_val)));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/tmr_pend.sv
module tmr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (clr)    pending <= 1'b0;
  end

  assert_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !pending);
  assert_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  import tmr_pkg::*;

  logic             cfg_load, stat_clr, expire, pending;
  logic             en_q, per_q;
  logic [CNT_W-1:0] reload_q, count;

  assign cfg_load = wr_en && (reg_sel_e'(wr_addr) == SEL_CFG);
  assign stat_clr = wr_en && (reg_sel_e'(wr_addr) == SEL_STAT) && wr_data[CLR_BIT];

  tmr_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .en_in(wr_data[EN_BIT]), .per_in(wr_data[PER_BIT]),
    .cnt_in(wr_data[CNT_W-1:0]), .expire(expire),
    .en_q(en_q), .per_q(per_q), .reload_q(reload_q)
  );

  tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .load_val(wr_data[CNT_W-1:0]), .tick(tick), .run(en_q),
    .per(per_q), .reload_val(reload_q), .count(count), .expire(expire)
  );

  tmr_pend u_pend (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(stat_clr),
    .pending(pending)
  );

  logic [PER_BIT-2:0] cnt_ext, rl_ext;
  assign cnt_ext = (PER_BIT-1)'(count);
  assign rl_ext  = (PER_BIT-1)'(reload_q);

  always_comb begin
    if (reg_sel_e'(rd_addr) == SEL_STAT) rd_data = pack_stat(pending, cnt_ext);
    else                                 rd_data = pack_cfg(en_q, per_q, rl_ext);
  end

  assign irq = pending;

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && wr_data == '0) |=> (!en_q && count == '0));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cfg_load) |=> !expire);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(int k, bit gaps);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic rd(logic a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  function automatic logic [28:0] exp_cnt(int n, int k, bit per);
    if (per) return 29'(n - (k % (n + 1)));
    return (k <= n) ? 29'(n - k) : 29'd0;
  endfunction

  function automatic logic exp_fired(int n, int k);
    return k >= n + 1;
  endfunction

  function automatic logic [31:0] stat_word(logic p, logic [28:0] c);
    return {1'b0, p, 1'b0, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(1'b0, v); chk("R1 cfg", v, 32'd0);
    rd(1'b1, v); chk("R1 stat", v, 32'd0);

    // R2 / R13 field layout
    wr(1'b0, 32'h2000_0005);
    rd(1'b0, v); chk("R13 bit29 ignored", v, 32'h0000_0005);
    wr(1'b0, 32'h5FFF_FFFF);
    rd(1'b0, v); chk("R13 max count", v, 32'h5FFF_FFFF);
    rd(1'b1, v); chk("R13 max count stat", v, stat_word(1'b0, 29'h1FFF_FFFF));
    wr(1'b0, 32'hC000_0009);
    rd(1'b0, v); chk("R2 cfg readback", v, 32'hC000_0009);

    // R4 disabled ignores ticks
    wr(1'b0, 32'h0000_0007);
    ticks(5, 0);
    rd(1'b1, v); chk("R4 count held", v, stat_word(1'b0, 29'd7));
    chk("R4 irq", {31'd0, irq}, 32'd0);

    // R3 / R5 one-shot expiry timing
    wr(1'b0, 32'h8000_0003);
    ticks(3, 0);
    chk("R3 no early irq", {31'd0, irq}, 32'd0);
    ticks(1, 0);
    chk("R3 irq on N+1", {31'd0, irq}, 32'd1);
    rd(1'b0, v); chk("R5 enable cleared", v, 32'h0000_0003);
    // R8 clear with bit30 clear has no effect
    wr(1'b1, 32'hBFFF_FFFF);
    chk("R8 no-op write", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h4000_0000);
    chk("R8 cleared", {31'd0, irq}, 32'd0);
    ticks(6, 0);
    chk("R5 no re-fire", {31'd0, irq}, 32'd0);
    rd(1'b1, v); chk("R5 count zero", v, stat_word(1'b0, 29'd0));

    // R6 / R9 periodic
    wr(1'b0, 32'hC000_0002);
    ticks(3, 0);
    chk("R6 first expiry", {31'd0, irq}, 32'd1);
    rd(1'b1, v); chk("R6 reload", v, stat_word(1'b1, 29'd2));
    ticks(2, 0);
    chk("R9 level held", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h4000_0000);
    ticks(1, 0);
    chk("R6 second expiry", {31'd0, irq}, 32'd1);

    // R12 expiry and clear together
    wr(1'b0, 32'hC000_0000);
    wr(1'b1, 32'h4000_0000);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h4000_0000;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R12 set wins", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h4000_0000);

    // R7 write zero stops
    wr(1'b0, 32'h8000_000A);
    ticks(3, 0);
    wr(1'b0, 32'h0);
    rd(1'b1, v); chk("R7 stat", v, 32'd0);
    rd(1'b0, v); chk("R7 cfg", v, 32'd0);
    ticks(4, 0);
    chk("R7 no irq", {31'd0, irq}, 32'd0);

    // R10 restart
    wr(1'b0, 32'h8000_000A);
    ticks(4, 0);
    wr(1'b0, 32'h8000_0003);
    ticks(3, 0);
    rd(1'b1, v); chk("R10 restarted", v, stat_word(1'b0, 29'd0));
    ticks(1, 0);
    chk("R10 fire", {31'd0, irq}, 32'd1);
    wr(1'b1, 32'h4000_0000);

    // R11 / R3 / R6 random trials
    for (int t = 0; t < 30; t++) begin
      int n, k;
      bit per;
      n = $urandom_range(0, 40);
      k = $urandom_range(0, 100);
      per = $urandom_range(0, 1);
      wr(1'b1, 32'h4000_0000);
      wr(1'b0, {1'b1, per, 1'b0, 29'(n)});
      ticks(k, 1);
      rd(1'b1, v);
      chk("R11 random stat", v, stat_word(exp_fired(n, k), exp_cnt(n, k, per)));
      chk("R3 random irq", {31'd0, irq}, {31'd0, exp_fired(n, k)});
      rd(1'b0, v);
      chk("R6 random cfg", v, {(per || k <= n), per, 1'b0, 29'(n)});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule